// File: doc/BRIEF.md
# Multi-Channel Compare Timer Core

This block is a parameterised up-counter with three output-compare channels. A prescaler elsewhere supplies a one-cycle tick strobe, and the counter advances by one on each tick while it is enabled. The block compares the count against three compare registers. It emits one-cycle event pulses on a match, and a rollover pulse when the count wraps from the all-ones value.

There are two counting modes. In free-run mode the counter covers its whole range and wraps to zero after all-ones. In restart mode, compare channel 1 also acts as the period: a tick seen while the count equals channel 1 sends the counter back to zero, so the period is the channel 1 value plus one. Writing channel 1 in restart mode also restarts the count. A separate enable-mode input selects whether re-enabling the block resumes the held count or starts again from zero.

Top module: `cmp_timer`

## Requirements
- R1: After reset the count is 0, all event outputs are low, and all three compare registers hold the all-ones value.
- R2: While en_i is high, each cycle with tick_i high advances the count by one. A cycle without tick_i leaves the count unchanged.
- R3: A tick seen while the count is all-ones wraps the count to 0 and pulses rov_evt_o.
- R4: In restart mode (free_run_i low), a tick seen while the count equals compare channel 1 sets the count to 0.
- R5: A tick seen while the count equals compare channel k pulses bit k-1 of cmp_evt_o (bit 0 is channel 1). Channels that match on the same count pulse together.
- R6: Event pulses last one cycle. They appear in the cycle after the tick edge, together with the count that the tick produced.
- R7: While en_i is low, the count holds and no event pulses.
- R8: A rising edge of en_i with en_restart_i high sets the count to 0 and produces no event in that cycle. With en_restart_i low, counting resumes from the held value.
- R9: Writing compare channel 1 (cmp_we_i bit 0) while in restart mode sets the count to 0. In free-run mode the same write leaves the count unchanged.
- R10: cnt_clr_i sets the count to 0 and suppresses all events in that cycle, even when a tick is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Counter enable |
| free_run_i | input | 1 | 1 = free-run mode, 0 = restart mode |
| en_restart_i | input | 1 | Restart from 0 on a rising edge of en_i |
| tick_i | input | 1 | Prescaled count strobe |
| cnt_clr_i | input | 1 | Request to clear the counter |
| cmp_we_i | input | N_CMP | Per-channel compare write strobes |
| cmp_wdata_i | input | CNT_W | Compare write data |
| count_o | output | CNT_W | Live count |
| cmp_evt_o | output | N_CMP | Compare event pulses |
| rov_evt_o | output | 1 | Rollover event pulse |

## Verification
The counting function is driven in free-run mode with compare values spread across the range. This separates per-channel matches from one another and tells tick cycles apart from idle cycles. It is then driven in restart mode with channel 1 as the period, which shows a return to zero at the match as distinct from wrapping at the end of the range. A full-range run with the reset compare values confirms the defaults, because all three channels and the rollover fire together at all-ones. Directed patterns then set clear requests, re-enables with and without enable-mode, and channel 1 writes against live ticks, which shows which of these wins.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned CNT_W_DEF = 32;
  localparam int unsigned N_CMP_DEF = 3;

  typedef enum logic [1:0] {
    NXT_HOLD = 2'd0,
    NXT_ZERO = 2'd1,
    NXT_INC  = 2'd2
  } nxt_e;
endpackage

// File: rtl/tmr_cmp_bank.sv
module tmr_cmp_bank #(
  parameter int unsigned CNT_W = 32,
  parameter int unsigned N_CMP = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_CMP-1:0] we_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic [CNT_W-1:0] count_i,
  output logic [N_CMP-1:0] match_o
);
  for (genvar k = 0; k < N_CMP; k++) begin : g_ch
    logic [CNT_W-1:0] cmp_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      cmp_q <= '1;
      else if (we_i[k]) cmp_q <= wdata_i;
    end
    assign match_o[k] = (count_i == cmp_q);
  end
endmodule

// File: rtl/tmr_ctrl.sv
module tmr_ctrl #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             free_run_i,
  input  logic             en_restart_i,
  input  logic             tick_i,
  input  logic             clr_i,
  input  logic             per_wr_i,
  input  logic             per_match_i,
  input  logic [CNT_W-1:0] count_i,
  output tmr_pkg::nxt_e    nxt_o,
  output logic             fire_o,
  output logic             wrap_o
);
  import tmr_pkg::*;

  logic en_q;
  logic en_rise, zero_req, run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= 1'b0;
    else         en_q <= en_i;
  end

  assign en_rise  = en_i & ~en_q;
  // restart sources take priority over a tick in the same cycle
  assign zero_req = clr_i | (en_rise & en_restart_i) | (per_wr_i & ~free_run_i);
  assign run      = en_i & tick_i & ~zero_req;

  always_comb begin
    nxt_o = NXT_HOLD;
    if (zero_req)                        nxt_o = NXT_ZERO;
    else if (run && !free_run_i && per_match_i) nxt_o = NXT_ZERO;
    else if (run)                        nxt_o = NXT_INC;
  end

  assign fire_o = run;
  assign wrap_o = run & (&count_i);
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  tmr_pkg::nxt_e    nxt_i,
  output logic [CNT_W-1:0] count_o
);
  import tmr_pkg::*;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else begin
      unique case (nxt_i)
        NXT_ZERO: cnt_q <= '0;
        NXT_INC:  cnt_q <= cnt_q + 1'b1;
        default:  cnt_q <= cnt_q;
      endcase
    end
  end

  assign count_o = cnt_q;
endmodule

// File: rtl/cmp_timer.sv
module cmp_timer #(
  parameter int unsigned CNT_W = tmr_pkg::CNT_W_DEF,
  parameter int unsigned N_CMP = tmr_pkg::N_CMP_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             free_run_i,
  input  logic             en_restart_i,
  input  logic             tick_i,
  input  logic             cnt_clr_i,
  input  logic [N_CMP-1:0] cmp_we_i,
  input  logic [CNT_W-1:0] cmp_wdata_i,
  output logic [CNT_W-1:0] count_o,
  output logic [N_CMP-1:0] cmp_evt_o,
  output logic             rov_evt_o
);
  import tmr_pkg::*;

  logic [N_CMP-1:0] match;
  nxt_e             nxt;
  logic             fire, wrap;
  logic [N_CMP-1:0] evt_q;
  logic             rov_q;

  tmr_cmp_bank #(.CNT_W(CNT_W), .N_CMP(N_CMP)) u_bank (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cmp_we_i),
    .wdata_i (cmp_wdata_i),
    .count_i (count_o),
    .match_o (match)
  );

  tmr_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .en_i         (en_i),
    .free_run_i   (free_run_i),
    .en_restart_i (en_restart_i),
    .tick_i       (tick_i),
    .clr_i        (cnt_clr_i),
    .per_wr_i     (cmp_we_i[0]),
    .per_match_i  (match[0]),
    .count_i      (count_o),
    .nxt_o        (nxt),
    .fire_o       (fire),
    .wrap_o       (wrap)
  );

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .nxt_i   (nxt),
    .count_o (count_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      evt_q <= '0;
      rov_q <= 1'b0;
    end else begin
      evt_q <= fire ? match : '0;
      rov_q <= wrap;
    end
  end

  assign cmp_evt_o = evt_q;
  assign rov_evt_o = rov_q;
endmodule

// File: rtl/tmr_chk.sv
module tmr_chk #(
  parameter int unsigned CNT_W = 32,
  parameter int unsigned N_CMP = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic             free_run_i,
  input logic             en_restart_i,
  input logic             tick_i,
  input logic             cnt_clr_i,
  input logic             per_we_i,
  input logic [CNT_W-1:0] count_o,
  input logic [N_CMP-1:0] cmp_evt_o,
  input logic             rov_evt_o
);
  AST_HOLD_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !cnt_clr_i && !(per_we_i && !free_run_i)) |=> $stable(count_o)); // R7
  AST_QUIET_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (cmp_evt_o == '0 && !rov_evt_o)); // R7
  AST_CLR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_clr_i |=> (count_o == '0)); // R10
  AST_CLR_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_clr_i |=> (cmp_evt_o == '0 && !rov_evt_o)); // R10
  AST_EVT_AFTER_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rov_evt_o || (|cmp_evt_o)) |-> $past(tick_i && en_i)); // R6
  AST_ROV_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rov_evt_o |-> (count_o == '0)); // R3
  AST_FREE_INC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && tick_i && free_run_i && !cnt_clr_i && !en_restart_i && count_o != '1)
      |=> (count_o == $past(count_o) + 1'b1)); // R2
endmodule

bind cmp_timer tmr_chk #(.CNT_W(CNT_W), .N_CMP(N_CMP)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .en_i         (en_i),
  .free_run_i   (free_run_i),
  .en_restart_i (en_restart_i),
  .tick_i       (tick_i),
  .cnt_clr_i    (cnt_clr_i),
  .per_we_i     (cmp_we_i[0]),
  .count_o      (count_o),
  .cmp_evt_o    (cmp_evt_o),
  .rov_evt_o    (rov_evt_o)
);

// File: tb/sim_cmp_timer.sv
`timescale 1ns/1ps
module sim_cmp_timer;
  localparam int W = 8;
  localparam int N = 3;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         en, fr, enr, tick, clr;
  logic [N-1:0] we;
  logic [W-1:0] wd;
  logic [W-1:0] cnt;
  logic [N-1:0] evt;
  logic         rov;

  int nvec = 0;
  int nerr = 0;

  always #2.5 clk = ~clk;

  cmp_timer #(.CNT_W(W), .N_CMP(N)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .free_run_i(fr),
    .en_restart_i(enr), .tick_i(tick), .cnt_clr_i(clr),
    .cmp_we_i(we), .cmp_wdata_i(wd),
    .count_o(cnt), .cmp_evt_o(evt), .rov_evt_o(rov)
  );

  // {en, free_run, tick, clr} | count | evt[2:0] | rov ; compares ch1=3 ch2=2 ch3=5
  localparam int NV = 17;
  localparam logic [15:0] VEC [NV] = '{
    {4'b1110, 8'd1, 3'b000, 1'b0},  // R2 R8 resume on enable
    {4'b1100, 8'd1, 3'b000, 1'b0},  // R2 no tick
    {4'b1110, 8'd2, 3'b000, 1'b0},  // R2
    {4'b1110, 8'd3, 3'b010, 1'b0},  // R5 ch2
    {4'b1110, 8'd4, 3'b001, 1'b0},  // R5 ch1, free-run passes
    {4'b0110, 8'd4, 3'b000, 1'b0},  // R7 disabled hold
    {4'b1110, 8'd5, 3'b000, 1'b0},  // R6 pulse gone
    {4'b1110, 8'd6, 3'b100, 1'b0},  // R5 ch3
    {4'b1001, 8'd0, 3'b000, 1'b0},  // R10 clear
    {4'b1010, 8'd1, 3'b000, 1'b0},  // R4
    {4'b1010, 8'd2, 3'b000, 1'b0},  // R4
    {4'b1010, 8'd3, 3'b010, 1'b0},  // R5
    {4'b1010, 8'd0, 3'b001, 1'b0},  // R4 restart at ch1
    {4'b1010, 8'd1, 3'b000, 1'b0},  // R4
    {4'b1011, 8'd0, 3'b000, 1'b0},  // R10 clear beats tick
    {4'b1010, 8'd1, 3'b000, 1'b0},  // R4
    {4'b1000, 8'd1, 3'b000, 1'b0}   // R2
  };

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [W-1:0] ec,
                     input logic [N-1:0] ee, input logic er);
    nvec++;
    if (cnt !== ec || evt !== ee || rov !== er) begin
      nerr++;
      $display("FAIL %s: got cnt=%0d evt=%b rov=%b, exp cnt=%0d evt=%b rov=%b",
               tag, cnt, evt, rov, ec, ee, er);
    end
  endtask

  task automatic set_in(input logic e, input logic f, input logic t, input logic c);
    en = e; fr = f; tick = t; clr = c;
  endtask

  task automatic wr(input int ch, input logic [W-1:0] v);
    we = '0; we[ch] = 1'b1; wd = v;
    cyc();
    we = '0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    set_in(1'b0, 1'b1, 1'b0, 1'b0);
    enr = 1'b0; we = '0; wd = '0;
    cyc(); cyc();
    rst_n = 1'b1;
    cyc();
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  endtask

  initial begin
    #200000;
    nerr++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    @(negedge clk);
    do_reset();
    chk("R1 reset state", 8'd0, 3'b000, 1'b0);

    wr(0, 8'd3); wr(1, 8'd2); wr(2, 8'd5);
    chk("R9 free-run ch1 write keeps count", 8'd0, 3'b000, 1'b0);

    for (int i = 0; i < NV; i++) begin
      set_in(VEC[i][15], VEC[i][14], VEC[i][13], VEC[i][12]);
      cyc();
      chk($sformatf("table vec %0d", i), VEC[i][11:4], VEC[i][3:1], VEC[i][0]);
    end

    // R1 R3: defaults are all-ones, so all channels and rollover fire at wrap
    do_reset();
    set_in(1'b1, 1'b1, 1'b1, 1'b0);
    for (int i = 0; i < 255; i++) cyc();
    chk("R2 count to max", 8'd255, 3'b000, 1'b0);
    cyc();
    chk("R1 R3 wrap with default compares", 8'd0, 3'b111, 1'b1);
    cyc();
    chk("R6 single-cycle pulse", 8'd1, 3'b000, 1'b0);

    // R8 enable-mode restart
    set_in(1'b0, 1'b1, 1'b1, 1'b0);
    cyc();
    chk("R7 hold while off", 8'd1, 3'b000, 1'b0);
    enr = 1'b1;
    set_in(1'b1, 1'b1, 1'b1, 1'b0);
    cyc();
    chk("R8 restart on enable", 8'd0, 3'b000, 1'b0);
    cyc();
    chk("R8 counting after restart", 8'd1, 3'b000, 1'b0);
    set_in(1'b0, 1'b1, 1'b0, 1'b0);
    cyc();
    enr = 1'b0;
    set_in(1'b1, 1'b1, 1'b1, 1'b0);
    cyc();
    chk("R8 resume without enable-mode", 8'd2, 3'b000, 1'b0);

    // R9 channel-1 write in each mode
    set_in(1'b1, 1'b1, 1'b0, 1'b0);
    wr(0, 8'd10);
    chk("R9 free-run write no restart", 8'd2, 3'b000, 1'b0);
    set_in(1'b1, 1'b0, 1'b1, 1'b0);
    wr(0, 8'd10);
    chk("R9 restart-mode write clears", 8'd0, 3'b000, 1'b0);
    for (int i = 0; i < 10; i++) cyc();
    chk("R4 reaches new period", 8'd10, 3'b000, 1'b0);
    cyc();
    chk("R4 restart at new period", 8'd0, 3'b001, 1'b0);

    finish_run();
  end
endmodule